// File: doc/BRIEF.md
# Triggered Reload Down-Counter Timer

This block is a down-counter with a reload register. It advances on a clock-enable pulse (`tick`) that a prescaler outside the block produces. Turning the counter on and starting a count are two separate actions. Setting the enable bit arms the timer, and it then waits for a start trigger. A trigger copies the reload value into the counter, and counting begins after that. A trigger can come from a control-register write or from a rising edge on an external pin.

When the count steps below zero, a sticky underflow flag is set. The mode bit then decides what happens next. In periodic mode the counter reloads and keeps running. In one-shot mode it returns to waiting for the next trigger. An interrupt output follows the flag, gated by an interrupt-enable bit.

Top module: `reload_timer`

## Requirements
- R1: After reset the state output is STOP (encoding STOP=0, WAIT=1, LOAD=2, RUN=3), the count is 0, and both the underflow flag and the interrupt are 0.
- R2: A control write (`wr_sel`=0) with bit 0 (enable) set and bit 4 (software trigger) clear moves the timer from STOP to WAIT at that clock edge. The count does not change.
- R3: A control write with enable and software trigger both set moves the timer from STOP to LOAD. A trigger while in WAIT also moves it to LOAD.
- R4: In LOAD, the first `tick` without a trigger copies the reload register (`wr_sel`=1) into the count and moves the timer to RUN.
- R5: In RUN the count decreases by one on each `tick` and holds when `tick` is low. In STOP and WAIT the count holds.
- R6: A `tick` in RUN with count 0 is an underflow. The count becomes 0xFFFF and the flag (control bit 3) is set. With mode bit 1 set, the timer goes to LOAD and reloads on the next `tick`.
- R7: With mode bit 1 clear, an underflow sends the timer to WAIT, and the count stays at 0xFFFF.
- R8: A trigger in RUN sends the timer to LOAD, so the count restarts from the reload value.
- R9: A control write with enable clear sends the timer to STOP at that edge from any state, and the count is kept.
- R10: The flag is sticky. A control write with bit 3 = 0 clears it, and a write with bit 3 = 1 leaves it unchanged. `irq` is 1 exactly when the flag and interrupt-enable (bit 2) are both 1.
- R11: When bit 5 (external trigger enable) is 1, a rising edge on `ext_trig` acts as a trigger. When bit 5 is 0, `ext_trig` has no effect.
- R12: A trigger in the same cycle as an underflow produces one move to LOAD, and the flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count clock-enable pulse |
| ext_trig | input | 1 | External trigger, rising edge active |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = control word, 1 = reload value |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| state | output | 2 | Machine state |
| uflow | output | 1 | Sticky underflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a trigger that lands in exactly the same cycle as an underflow. Two inputs that are normally independent must coincide at a counter value of zero. The bench counts the timer down to 0 with single-tick steps. It then drives one cycle that carries the final `tick` and a software-trigger control write together. After that cycle it checks the state, the count and the flag, and then it checks that exactly one reload follows.

// File: rtl/rtim_pkg.sv
package rtim_pkg;
  typedef enum logic [1:0] {
    ST_STOP = 2'd0,
    ST_WAIT = 2'd1,
    ST_LOAD = 2'd2,
    ST_RUN  = 2'd3
  } rtim_state_e;

  localparam int CB_EN    = 0;
  localparam int CB_MODE  = 1;
  localparam int CB_IE    = 2;
  localparam int CB_FLAG  = 3;
  localparam int CB_TRIG  = 4;
  localparam int CB_EXTEN = 5;
endpackage

// File: rtl/rtim_regs.sv
module rtim_regs
  import rtim_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_sel,
  input  logic [W-1:0] wr_data,
  input  logic         ext_trig,
  input  logic         uf_pulse,
  output logic         en_eff,
  output logic         mode_q,
  output logic         trig,
  output logic [W-1:0] reload_q,
  output logic         flag_q,
  output logic         irq_q
);
  logic en_q, ie_q, exten_q, ext_q;
  logic ctrl_wr, ext_edge, flag_nxt, ie_nxt;

  assign ctrl_wr  = wr_en && !wr_sel;
  assign en_eff   = ctrl_wr ? wr_data[CB_EN] : en_q;
  assign ext_edge = ext_trig && !ext_q;
  assign trig     = (ctrl_wr && wr_data[CB_TRIG]) || (exten_q && ext_edge);
  assign ie_nxt   = ctrl_wr ? wr_data[CB_IE] : ie_q;

  always_comb begin
    flag_nxt = flag_q;
    if (ctrl_wr && !wr_data[CB_FLAG]) flag_nxt = 1'b0;
    if (uf_pulse) flag_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      mode_q   <= 1'b0;
      ie_q     <= 1'b0;
      exten_q  <= 1'b0;
      ext_q    <= 1'b0;
      reload_q <= '0;
      flag_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      ext_q  <= ext_trig;
      flag_q <= flag_nxt;
      irq_q  <= flag_nxt && ie_nxt;
      ie_q   <= ie_nxt;
      en_q   <= en_eff;
      if (ctrl_wr) begin
        mode_q  <= wr_data[CB_MODE];
        exten_q <= wr_data[CB_EXTEN];
      end
      if (wr_en && wr_sel) reload_q <= wr_data;
    end
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !ctrl_wr) |=> flag_q); // R10
  AST_IRQ_GATE: assert property (@(posedge clk) disable iff (rst)
    irq_q == (flag_q && ie_q)); // R10
  AST_EXT_MASKED: assert property (@(posedge clk) disable iff (rst)
    (!exten_q && !ctrl_wr) |-> !trig); // R11
endmodule

// File: rtl/rtim_core.sv
module rtim_core
  import rtim_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         en,
  input  logic         mode,
  input  logic         trig,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt_q,
  output rtim_state_e  st_q,
  output logic         uf_pulse
);
  localparam logic [W-1:0] ZERO = '0;
  rtim_state_e st_nxt;
  logic do_load, do_dec;

  assign do_load  = en && (st_q == ST_LOAD) && tick && !trig;
  assign do_dec   = en && (st_q == ST_RUN) && tick;
  assign uf_pulse = do_dec && (cnt_q == ZERO);

  always_comb begin
    st_nxt = st_q;
    if (!en) st_nxt = ST_STOP;
    else begin
      unique case (st_q)
        ST_STOP, ST_WAIT: st_nxt = trig ? ST_LOAD : ST_WAIT;
        ST_LOAD:          st_nxt = (tick && !trig) ? ST_RUN : ST_LOAD;
        ST_RUN: begin
          if (trig)          st_nxt = ST_LOAD;
          else if (uf_pulse) st_nxt = mode ? ST_LOAD : ST_WAIT;
          else               st_nxt = ST_RUN;
        end
        default:           st_nxt = ST_STOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_STOP;
      cnt_q <= '0;
    end else begin
      st_q <= st_nxt;
      if (do_load)     cnt_q <= reload;
      else if (do_dec) cnt_q <= cnt_q - 1'b1;
    end
  end

  AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
    !en |=> st_q == ST_STOP); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_STOP || st_q == ST_WAIT) |=> cnt_q == $past(cnt_q)); // R5
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    (en && st_q == ST_LOAD && tick && !trig) |=> (cnt_q == $past(reload) && st_q == ST_RUN)); // R4
  AST_RUN_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && st_q == ST_RUN && tick) |=> cnt_q == $past(cnt_q) - 1'b1); // R5
  AST_ONESHOT_END: assert property (@(posedge clk) disable iff (rst)
    (en && st_q == ST_RUN && tick && cnt_q == ZERO && !trig && !mode) |=> st_q == ST_WAIT); // R7
  AST_TRIG_LOADS: assert property (@(posedge clk) disable iff (rst)
    (en && trig) |=> st_q == ST_LOAD); // R3
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import rtim_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ext_trig,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count,
  output logic [1:0]       state,
  output logic             uflow,
  output logic             irq
);
  logic en_eff, mode_q, trig, uf_pulse;
  logic [CNT_W-1:0] reload_q;
  rtim_state_e st_q;

  rtim_regs #(.W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .ext_trig(ext_trig), .uf_pulse(uf_pulse), .en_eff(en_eff), .mode_q(mode_q),
    .trig(trig), .reload_q(reload_q), .flag_q(uflow), .irq_q(irq)
  );

  rtim_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .en(en_eff), .mode(mode_q), .trig(trig),
    .reload(reload_q), .cnt_q(count), .st_q(st_q), .uf_pulse(uf_pulse)
  );

  assign state = st_q;

  AST_UNDERFLOW_FLAGS: assert property (@(posedge clk) disable iff (rst)
    uf_pulse |=> (uflow && count == '1)); // R6
endmodule

// File: tb/reload_timer_test.sv
module reload_timer_test;
  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, ext_trig = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic [1:0] state;
  logic uflow, irq;
  int checks = 0, fails = 0;

  localparam logic [1:0] S_STOP = 2'd0, S_WAIT = 2'd1, S_LOAD = 2'd2, S_RUN = 2'd3;
  localparam logic [15:0] EN = 16'h1, MODE = 16'h2, IE = 16'h4, KEEP = 16'h8,
                          TRG = 16'h10, EXTEN = 16'h20;

  always #10 clk = ~clk;

  reload_timer uut (.clk(clk), .rst(rst), .tick(tick), .ext_trig(ext_trig),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .count(count),
    .state(state), .uflow(uflow), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, result visible at following negedge
  task automatic step(input logic t, input logic w, input logic s, input logic [15:0] d, input logic e);
    tick = t; wr_en = w; wr_sel = s; wr_data = d; ext_trig = e;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0; ext_trig = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; step(0, 0, 0, 0, 0); step(0, 0, 0, 0, 0); rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 state", state, S_STOP); chk("R1 count", count, 0);
    chk("R1 flag", uflow, 0); chk("R1 irq", irq, 0);
  endtask

  task automatic t_periodic();
    do_reset();
    step(0, 1, 1, 16'd3, 0);
    step(0, 1, 0, EN | KEEP, 0);
    chk("R2 wait", state, S_WAIT); chk("R2 count", count, 0);
    step(1, 0, 0, 0, 0);
    chk("R5 wait hold", count, 0);
    step(0, 1, 0, EN | MODE | KEEP | TRG, 0);
    chk("R3 wait->load", state, S_LOAD);
    step(1, 0, 0, 0, 0);
    chk("R4 loaded", count, 3); chk("R4 run", state, S_RUN);
    step(0, 0, 0, 0, 0);
    chk("R5 no tick hold", count, 3);
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    chk("R5 dec", count, 1);
    step(1, 0, 0, 0, 0); chk("R5 zero", count, 0); chk("R6 no flag yet", uflow, 0);
    step(1, 0, 0, 0, 0);
    chk("R6 wrap", count, 16'hFFFF); chk("R6 flag", uflow, 1);
    chk("R6 load", state, S_LOAD); chk("R10 irq masked", irq, 0);
    step(1, 0, 0, 0, 0);
    chk("R6 reload", count, 3); chk("R6 run", state, S_RUN);
    step(0, 1, 0, EN | MODE | IE | KEEP, 0);
    chk("R10 keep flag", uflow, 1); chk("R10 irq on", irq, 1);
    step(1, 0, 0, 0, 0); chk("R10 sticky", uflow, 1);
    step(0, 1, 0, EN | MODE | IE, 0);
    chk("R10 cleared", uflow, 0); chk("R10 irq off", irq, 0);
    step(0, 1, 0, MODE, 0);
    chk("R9 stop", state, S_STOP); chk("R9 count kept", count, 2);
    step(1, 0, 0, 0, 0); chk("R5 stop hold", count, 2);
  endtask

  task automatic t_oneshot();
    do_reset();
    step(0, 1, 1, 16'd1, 0);
    step(0, 1, 0, EN | TRG | KEEP, 0);
    chk("R3 stop->load", state, S_LOAD);
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    chk("R7 wrap", count, 16'hFFFF); chk("R7 wait", state, S_WAIT);
    step(1, 0, 0, 0, 0); chk("R7 hold", count, 16'hFFFF);
  endtask

  task automatic t_retrigger();
    do_reset();
    step(0, 1, 1, 16'd10, 0);
    step(0, 1, 0, EN | MODE | TRG | KEEP, 0);
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    chk("R8 pre", count, 8);
    step(0, 1, 0, EN | MODE | TRG | KEEP, 0);
    chk("R8 load", state, S_LOAD); chk("R8 count held", count, 8);
    step(1, 0, 0, 0, 0); chk("R8 restart", count, 10);
  endtask

  task automatic t_ext();
    do_reset();
    step(0, 1, 1, 16'd5, 0);
    step(0, 1, 0, EN | KEEP, 0);
    step(0, 0, 0, 0, 1); step(0, 0, 0, 0, 0);
    chk("R11 masked", state, S_WAIT);
    step(0, 1, 0, EN | EXTEN | KEEP, 0);
    step(0, 0, 0, 0, 1);
    chk("R11 edge", state, S_LOAD);
    step(1, 0, 0, 0, 0); chk("R11 loaded", count, 5);
  endtask

  task automatic t_coincide();
    do_reset();
    step(0, 1, 1, 16'd1, 0);
    step(0, 1, 0, EN | TRG | KEEP, 0);
    step(1, 0, 0, 0, 0); step(1, 0, 0, 0, 0);
    chk("R12 at zero", count, 0);
    step(1, 1, 0, EN | TRG | KEEP, 0);
    chk("R12 load", state, S_LOAD); chk("R12 flag", uflow, 1);
    step(1, 0, 0, 0, 0);
    chk("R12 single reload", count, 1); chk("R12 run", state, S_RUN);
  endtask

  initial begin
    @(negedge clk);
    t_reset(); t_periodic(); t_oneshot(); t_retrigger(); t_ext(); t_coincide();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule